// File: doc/BRIEF.md
# Dithered Fractional-Resolution DDS Phase Accumulator

This block is the numeric core of a direct digital synthesizer whose frequency resolution is finer than its phase accumulator. A 64-bit tuning value is requested; its upper 48 bits form an integer step `k` and its lower 16 bits form a fraction. A small fraction accumulator decides, cycle by cycle, whether the 48-bit phase accumulator advances by `k` or by `k+1`. Over time the average step equals the full 64-bit value divided by 2^16, so the output frequency is the sample clock times the 64-bit value divided by 2^64.

With a 100 MHz sample clock (a 20 MHz reference multiplied by five), the tuning value for an output frequency `f` is `f * 2^64 / 100 MHz`. Typical targets sit within ±100 ppm of 19.40 MHz or 19.44 MHz. The accumulator phase, its top bits as a phase word for a sine lookup, and the step applied in the present cycle are all visible at the ports. Filtering, conversion to analog and the clock loops around the block are outside it.

Top module: `dds_dither_top`

## Requirements
- R1: After a synchronous active-low reset, `phase_o`, `phase_word_o` and `tune_word_o` are all zero, and the stored tuning value is zero.
- R2: `tune_word_o` always equals either `k` or `k+1` (modulo 2^48), where `k` is `tune_i[63:16]` of the most recently loaded value.
- R3: Starting from the cycle after a load, exactly `tune_i[15:0]` of the next 65536 cycles apply `k+1`.
- R4: With a zero fraction, `tune_word_o` equals `k` in every cycle.
- R5: On each clock edge outside reset, `phase_o` advances by the `tune_word_o` value present before that edge, modulo 2^48.
- R6: After N cycles following a load, `phase_o` agrees within one count with the top 48 bits of a 64-bit reference that starts at `{phase_o, 16'h0}` and advances by the full tuning value each cycle.
- R7: A high `load_i` at a clock edge captures `tune_i`; the new value applies from the following cycle, the fraction accumulator restarts at zero, and the phase accumulator is not cleared.
- R8: When `k` is all ones and the fraction is nonzero, a `k+1` cycle applies a step of zero (wrap modulo 2^48).
- R9: `phase_word_o` equals `phase_o[47:34]`.
- R10: While `load_i` is low, changes on `tune_i` have no effect on the applied step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Capture strobe for `tune_i` |
| tune_i | input | 64 | Requested tuning value: integer step in [63:16], fraction in [15:0] |
| phase_o | output | 48 | Phase accumulator contents |
| phase_word_o | output | 14 | Top bits of the phase accumulator |
| tune_word_o | output | 48 | Step applied to the accumulator in the current cycle |

## Verification
The assertions assume `load_i` and `tune_i` carry known values in every cycle after reset and place no limit on when loads arrive or how close together they are; the sequencing checks treat a load in any cycle as legal. The stimulus changes inputs only at the falling edge, never leaves them undriven, and holds reset for several cycles before releasing it so that every past-value reference already refers to cycles since reset. Tuning values come from the target frequencies and from hand-picked corner words (zero fraction, all-ones integer), which keeps the long-run phase comparison and the carry count within the block's stated arithmetic.

// File: rtl/dds_dither_pkg.sv
// Package: shared widths for the dithered DDS accumulator.
// Assumes: the tuning value is the concatenation of integer and fraction.
package dds_dither_pkg;
    localparam int unsigned DEF_ACC_W   = 48;
    localparam int unsigned DEF_FRAC_W  = 16;
    localparam int unsigned DEF_PHOUT_W = 14;
endpackage

// File: rtl/dds_tune_reg.sv
// Module: dds_tune_reg
// Holds the integer step and fraction of the requested tuning value.
// Assumes: load_i is a single-cycle or multi-cycle strobe; each high
// cycle captures tune_i. Reset is synchronous, active low.
module dds_tune_reg #(
    parameter int unsigned ACC_W  = dds_dither_pkg::DEF_ACC_W,
    parameter int unsigned FRAC_W = dds_dither_pkg::DEF_FRAC_W,
    localparam int unsigned TUNE_W = ACC_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [TUNE_W-1:0] tune_i,
    output logic [ACC_W-1:0]  int_o,
    output logic [FRAC_W-1:0] frac_o
);
    // Capture the split tuning value on a load, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_o  <= '0;
            frac_o <= '0;
        end else if (load_i) begin
            int_o  <= tune_i[TUNE_W-1:FRAC_W];
            frac_o <= tune_i[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/dds_frac_seq.sv
// Module: dds_frac_seq
// Fraction accumulator that chooses k or k+1 each cycle. The carry out of
// (accumulator + fraction) selects k+1, so over 2^FRAC_W cycles from a
// cleared start exactly `fraction` cycles use k+1.
// Assumes: int_i/frac_i come from registers; k+1 wraps modulo 2^ACC_W.
module dds_frac_seq #(
    parameter int unsigned ACC_W  = dds_dither_pkg::DEF_ACC_W,
    parameter int unsigned FRAC_W = dds_dither_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ACC_W-1:0]  int_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [ACC_W-1:0]  step_o,
    output logic [FRAC_W-1:0] facc_o
);
    logic [FRAC_W:0] sum;
    logic            carry;

    // Form the fraction sum, its carry and the applied step.
    always_comb begin
        sum    = {1'b0, facc_o} + {1'b0, frac_i};
        carry  = sum[FRAC_W];
        step_o = int_i + ACC_W'(carry);
    end

    // Advance the fraction accumulator; restart it when a new value loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            facc_o <= '0;
        end else if (load_i) begin
            facc_o <= '0;
        end else begin
            facc_o <= sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/dds_phase_acc.sv
// Module: dds_phase_acc
// Phase accumulator: adds the applied step every cycle, modulo 2^ACC_W,
// and exposes the top PHOUT_W bits as the phase word.
// Assumes: loads never clear the phase; only reset does.
module dds_phase_acc #(
    parameter int unsigned ACC_W   = dds_dither_pkg::DEF_ACC_W,
    parameter int unsigned PHOUT_W = dds_dither_pkg::DEF_PHOUT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ACC_W-1:0]   step_i,
    output logic [ACC_W-1:0]   phase_o,
    output logic [PHOUT_W-1:0] word_o
);
    // Accumulate the applied step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= '0;
        end else begin
            phase_o <= phase_o + step_i;
        end
    end

    // Take the most significant bits as the phase word.
    always_comb begin
        word_o = phase_o[ACC_W-1 -: PHOUT_W];
    end
endmodule

// File: rtl/dds_dither_top.sv
// Module: dds_dither_top
// Dithered fractional-resolution DDS accumulator. A 64-bit tuning value
// (integer step over fraction) drives a 48-bit phase accumulator whose
// step alternates between k and k+1 so the mean step is tune_i / 2^16.
// Assumes: synchronous active-low reset; inputs known after reset.
module dds_dither_top #(
    parameter int unsigned ACC_W   = dds_dither_pkg::DEF_ACC_W,
    parameter int unsigned FRAC_W  = dds_dither_pkg::DEF_FRAC_W,
    parameter int unsigned PHOUT_W = dds_dither_pkg::DEF_PHOUT_W,
    localparam int unsigned TUNE_W = ACC_W + FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [TUNE_W-1:0]  tune_i,
    output logic [ACC_W-1:0]   phase_o,
    output logic [PHOUT_W-1:0] phase_word_o,
    output logic [ACC_W-1:0]   tune_word_o
);
    logic [ACC_W-1:0]  int_word;
    logic [FRAC_W-1:0] frac_word;
    logic [FRAC_W-1:0] facc_val;

    dds_tune_reg #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_tune (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .tune_i (tune_i),
        .int_o  (int_word),
        .frac_o (frac_word)
    );

    dds_frac_seq #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .int_i  (int_word),
        .frac_i (frac_word),
        .step_o (tune_word_o),
        .facc_o (facc_val)
    );

    dds_phase_acc #(.ACC_W(ACC_W), .PHOUT_W(PHOUT_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (tune_word_o),
        .phase_o (phase_o),
        .word_o  (phase_word_o)
    );
endmodule

// File: rtl/dds_dither_chk.sv
// Module: dds_dither_chk
// Assertion checker for dds_dither_top, attached by bind below.
// Assumes: reset is held for at least one edge at start of time.
module dds_dither_chk #(
    parameter int unsigned ACC_W  = 48,
    parameter int unsigned FRAC_W = 16,
    localparam int unsigned TUNE_W = ACC_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [TUNE_W-1:0] tune_i,
    input logic [ACC_W-1:0]  phase_o,
    input logic [ACC_W-1:0]  tune_word_o,
    input logic [ACC_W-1:0]  int_word,
    input logic [FRAC_W-1:0] facc_val
);
    // R1: first cycle out of reset shows a cleared accumulator and step.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (phase_o == '0 && tune_word_o == '0));

    // R2: applied step is k or k+1 modulo 2^ACC_W.
    a_r2_step_k_or_k1: assert property (@(posedge clk) disable iff (!rst_n)
        ACC_W'(tune_word_o - int_word) <= ACC_W'(1));

    // R5: phase advances by the previous step.
    a_r5_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> phase_o == ACC_W'($past(phase_o) + $past(tune_word_o)));

    // R7: a load captures the integer step and restarts the fraction.
    a_r7_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_i)) |->
            (facc_val == '0 && int_word == $past(tune_i[TUNE_W-1:FRAC_W])));

    // R10: without a load the integer step holds.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_i)) |-> $stable(int_word));
endmodule

bind dds_dither_top dds_dither_chk #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .tune_i      (tune_i),
    .phase_o     (phase_o),
    .tune_word_o (tune_word_o),
    .int_word    (int_word),
    .facc_val    (facc_val)
);

// File: tb/test_dds_dither_top.sv
// Directed bench for dds_dither_top: one task per scenario.
module test_dds_dither_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [63:0] tune_i = '0;
    logic [47:0] phase_o;
    logic [13:0] phase_word_o;
    logic [47:0] tune_word_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dds_dither_top i_dds_dither_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .tune_i       (tune_i),
        .phase_o      (phase_o),
        .phase_word_o (phase_word_o),
        .tune_word_o  (tune_word_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] tune_for(input longint unsigned f_hz);
        logic [127:0] t;
        t = ((128'd1 << 64) * 128'(f_hz)) / 128'd100000000;
        return t[63:0];
    endfunction

    // Load a value; the phase must continue from its old value plus old step (R7).
    task automatic do_load(input logic [63:0] v);
        logic [47:0] ph, tw;
        @(negedge clk);
        ph = phase_o; tw = tune_word_o;
        load_i = 1'b1; tune_i = v;
        @(negedge clk);
        load_i = 1'b0;
        chk(phase_o === ph + tw, "R7 phase kept across load", 64'(phase_o), 64'(ph + tw));
    endtask

    task automatic t_reset;
        chk(phase_o === '0, "R1 phase", 64'(phase_o), 0);
        chk(phase_word_o === '0, "R1 phase word", 64'(phase_word_o), 0);
        chk(tune_word_o === '0, "R1 step", 64'(tune_word_o), 0);
    endtask

    task automatic t_load_timing;
        logic [47:0] p;
        do_load({48'd5, 16'd0});
        chk(tune_word_o === 48'd5, "R7 new step applies", 64'(tune_word_o), 5);
        p = phase_o;
        @(negedge clk);
        chk(phase_o === p + 48'd5, "R5 phase step", 64'(phase_o), 64'(p + 48'd5));
    endtask

    task automatic t_zero_frac;
        logic [47:0] k = 48'h0123_4567_89AB;
        logic [47:0] p;
        int bad_k = 0, bad_p = 0;
        do_load({k, 16'h0000});
        for (int i = 0; i < 200; i++) begin
            p = phase_o;
            if (tune_word_o !== k) bad_k++;
            @(negedge clk);
            if (phase_o !== p + k) bad_p++;
            if (phase_word_o !== phase_o[47:34]) bad_p++;
        end
        chk(bad_k == 0, "R4 zero fraction keeps k", 64'(bad_k), 0);
        chk(bad_p == 0, "R5/R9 phase step and word", 64'(bad_p), 0);
    endtask

    task automatic t_hold;
        logic [47:0] tw;
        tw = tune_word_o;
        @(negedge clk);
        tune_i = 64'hDEAD_BEEF_0000_FFFF;
        repeat (3) @(negedge clk);
        chk(tune_word_o === tw, "R10 ignored without load", 64'(tune_word_o), 64'(tw));
    endtask

    task automatic t_wrap;
        do_load({48'hFFFF_FFFF_FFFF, 16'h8000});
        chk(tune_word_o === 48'hFFFF_FFFF_FFFF, "R8 first cycle k", 64'(tune_word_o), 64'(48'hFFFF_FFFF_FFFF));
        @(negedge clk);
        chk(tune_word_o === 48'h0, "R8 k+1 wraps to zero", 64'(tune_word_o), 0);
        @(negedge clk);
        chk(tune_word_o === 48'hFFFF_FFFF_FFFF, "R8 back to k", 64'(tune_word_o), 64'(48'hFFFF_FFFF_FFFF));
    endtask

    task automatic t_carry_count(input longint unsigned f_hz);
        logic [63:0] v = tune_for(f_hz);
        logic [47:0] k = v[63:16];
        int ones = 0, stray = 0;
        do_load(v);
        for (int i = 0; i < 65536; i++) begin
            if (tune_word_o === k + 48'd1) ones++;
            else if (tune_word_o !== k) stray++;
            @(negedge clk);
        end
        chk(stray == 0, "R2 step is k or k+1", 64'(stray), 0);
        chk(ones == int'(v[15:0]), "R3 k+1 count equals fraction", 64'(ones), 64'(v[15:0]));
    endtask

    task automatic t_reference(input longint unsigned f_hz, input int n);
        logic [63:0] v = tune_for(f_hz);
        logic [63:0] ref64;
        logic [47:0] d;
        logic [47:0] p0;
        do_load(v);
        p0 = phase_o;
        repeat (n) @(negedge clk);
        ref64 = {p0, 16'h0} + 64'(n) * v;
        d = phase_o - ref64[63:16];
        chk(d == 48'd0 || d == 48'd1 || d == 48'hFFFF_FFFF_FFFF,
            "R6 phase vs 64-bit reference", 64'(phase_o), 64'(ref64[63:16]));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_timing();
        t_zero_frac();
        t_hold();
        t_wrap();
        t_carry_count(64'd19400000);
        t_carry_count(64'd19441944);
        t_reference(64'd19440000, 20000);
        t_reference(64'd19401940, 20000);
        t_reference(64'd19398060, 7777);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule